// File: doc/BRIEF.md
# Post-Increment Load/Store Address Unit

This block owns the three address pointers of a 32-bit processor's memory path: a data pointer, a peripheral pointer and a stack pointer. Each cycle it may accept one decoded memory operation, along with an access size and a post-increment flag. In the same cycle it drives a sized request: a byte address, byte-lane enables, lane-replicated write data and a write strobe. It then updates the pointer that the operation names. Read requests return data one cycle later. That data is shifted down from its byte lanes and zero-extended to 32 bits.

Data-space and peripheral-space operations each use their own pointer. When the post-increment flag is set, that pointer advances by the access width. The stack grows toward higher addresses. A push writes at the stack pointer and then adds 4. A pull first subtracts 4 and then reads. Two further stack operations read or write the word at the stack pointer and leave the pointer unchanged. Software can load any of the three pointers directly through a set port.

Top module: `addr_step_unit`

## Requirements
- R1: After reset all three pointers are 0, so the first access of each kind addresses byte 0. `ld_valid_o` is low.
- R2: Operation codes are 0 data load, 1 data store, 2 peripheral load, 3 peripheral store, 4 push, 5 pull, 6 stack store, 7 stack load. Codes 0 and 1 use the data pointer with `mem_per_o`=0. Codes 2 and 3 use the peripheral pointer with `mem_per_o`=1. Codes 4 to 7 use the stack pointer with `mem_per_o`=0. An operation moves no pointer other than its own.
- R3: The size codes are 0 byte, 1 short and 2 long; code 3 acts as long. A data or peripheral access with `post_inc_i`=1 adds 1, 2 or 4 to its pointer after the access.
- R4: A data or peripheral access with `post_inc_i`=0 leaves its pointer unchanged.
- R5: A push writes a long word at the stack pointer and then raises the pointer by 4. Size and post-increment are ignored.
- R6: A pull reads the long word at the stack pointer minus 4, and the pointer becomes that value.
- R7: A stack store or stack load accesses the long word at the stack pointer and does not move the pointer.
- R8: Lane enables are little-endian. A byte enables lane `addr[1:0]`. A short enables lanes 1:0 when `addr[1]`=0 and lanes 3:2 when it is 1. A long enables all four lanes. Write data repeats the low byte (byte) or the low half (short) across the bus.
- R9: One cycle after a read request, `ld_valid_o` is 1. `ld_data_o` then holds the addressed byte or short from `mem_rdata_i`, zero-extended, or the whole word for a long. A write request does not raise `ld_valid_o`.
- R10: With `set_en_i`=1, the pointer chosen by `set_sel_i` (0 data, 1 peripheral, 2 stack, 3 none) takes `set_val_i` at the clock edge. This overrides any move of the same pointer in that cycle.
- R11: `mem_req_o` follows `op_valid_i`. With no valid operation, `mem_be_o` is 0 and `mem_we_o` is 0. `mem_we_o` is 1 only for codes 1, 3, 4 and 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Access size code |
| post_inc_i | input | 1 | Advance pointer after access |
| st_data_i | input | 32 | Register value to store |
| set_en_i | input | 1 | Load a pointer directly |
| set_sel_i | input | 2 | Pointer to load |
| set_val_i | input | AW | Value loaded into the pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write strobe |
| mem_per_o | output | 1 | Peripheral space select |
| mem_addr_o | output | AW | Byte address |
| mem_be_o | output | DW/8 | Byte lane enables |
| mem_wdata_o | output | DW | Lane-replicated write data |
| mem_rdata_i | input | DW | Read data, one cycle after request |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Aligned, zero-extended load result |

## Verification
Some rules are checked by the assertions on every cycle:
- the stack pointer moves by exactly +4 on a push, by -4 on a pull, and not at all on a stack store or stack load;
- the data pointer holds during an access without post-increment;
- lane counts match the access size;
- idle cycles drive no lanes and no strobe;
- every read is followed by a load-valid cycle.

The exact address sequence for a chain of mixed-size post-increments, the override of a set over a concurrent increment, lane and write-data replication at each offset, and the zero-extension of extracted bytes and shorts depend on chosen values. Only the bench's directed scenarios show these.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam int REG_W = 32;
  localparam int NPTR  = 3;

  typedef enum logic [2:0] {
    OP_LD_DAT = 3'd0, OP_ST_DAT = 3'd1, OP_LD_PER = 3'd2, OP_ST_PER = 3'd3,
    OP_PUSH   = 3'd4, OP_PULL   = 3'd5, OP_ST_STK = 3'd6, OP_LD_STK = 3'd7
  } asu_op_e;

  localparam logic [1:0] SEL_DAT = 2'd0;
  localparam logic [1:0] SEL_PER = 2'd1;
  localparam logic [1:0] SEL_STK = 2'd2;

  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic op_writes(input asu_op_e op);
    return op inside {OP_ST_DAT, OP_ST_PER, OP_PUSH, OP_ST_STK};
  endfunction
endpackage

// File: rtl/asu_ptr_regs.sv
module asu_ptr_regs #(
  parameter int AW   = 32,
  parameter int NPTR = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     set_en_i,
  input  logic [1:0]               set_sel_i,
  input  logic [AW-1:0]            set_val_i,
  input  logic [NPTR-1:0]          add_en_i,
  input  logic [NPTR-1:0]          sub_en_i,
  input  logic [AW-1:0]            amt_i,
  output logic [NPTR-1:0][AW-1:0]  ptr_o
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic hit;
    assign hit = set_en_i && (int'(set_sel_i) == g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           ptr_o[g] <= '0;
      else if (hit)          ptr_o[g] <= set_val_i;
      else if (add_en_i[g])  ptr_o[g] <= ptr_o[g] + amt_i;
      else if (sub_en_i[g])  ptr_o[g] <= ptr_o[g] - amt_i;
    end
  end
endmodule

// File: rtl/asu_lane_gen.sv
module asu_lane_gen #(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic          req_i,
  input  logic [OW-1:0] addr_lo_i,
  input  logic [3:0]    nbytes_i,
  input  logic [31:0]   wdata_i,
  output logic [NL-1:0] be_o,
  output logic [DW-1:0] wdata_o
);
  always_comb begin
    int nb, off;
    nb  = int'(nbytes_i);
    off = int'(addr_lo_i) & ~(nb - 1);  // align down to access size
    for (int i = 0; i < NL; i++) begin
      be_o[i]          = req_i && (i >= off) && (i < off + nb);
      wdata_o[8*i +: 8] = wdata_i[8*(i & (nb - 1)) +: 8];
    end
  end
endmodule

// File: rtl/asu_load_align.sv
module asu_load_align #(
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [OW-1:0] addr_lo_i,
  input  logic [3:0]    nbytes_i,
  input  logic [DW-1:0] rdata_i,
  output logic          ld_valid_o,
  output logic [31:0]   ld_data_o
);
  logic [OW-1:0] off_q;
  logic [3:0]    nb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      off_q      <= '0;
      nb_q       <= 4'd4;
    end else begin
      ld_valid_o <= cap_i;
      if (cap_i) begin
        off_q <= addr_lo_i & ~OW'(nbytes_i - 4'd1);
        nb_q  <= nbytes_i;
      end
    end
  end

  always_comb begin
    ld_data_o = '0;
    for (int j = 0; j < 4; j++) begin
      if (j < int'(nb_q) && (int'(off_q) + j) < NL)
        ld_data_o[8*j +: 8] = rdata_i[8*(int'(off_q) + j) +: 8];
    end
  end
endmodule

// File: rtl/addr_step_unit.sv
module addr_step_unit
  import asu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NL = DW / 8,
  localparam int OW = $clog2(NL)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic          post_inc_i,
  input  logic [31:0]   st_data_i,
  input  logic          set_en_i,
  input  logic [1:0]    set_sel_i,
  input  logic [AW-1:0] set_val_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          mem_per_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [NL-1:0] mem_be_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          ld_valid_o,
  output logic [31:0]   ld_data_o
);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  asu_op_e                   op;
  logic                      is_dat, is_per, is_stk;
  logic [3:0]                nbytes;
  logic [NPTR-1:0]           add_en, sub_en;
  logic [AW-1:0]             amt;
  logic [NPTR-1:0][AW-1:0]   ptr;
  logic [AW-1:0]             dat_q, per_q, stk_q;

  assign op     = asu_op_e'(op_i);
  assign dat_q  = ptr[SEL_DAT];
  assign per_q  = ptr[SEL_PER];
  assign stk_q  = ptr[SEL_STK];
  assign is_dat = op inside {OP_LD_DAT, OP_ST_DAT};
  assign is_per = op inside {OP_LD_PER, OP_ST_PER};
  assign is_stk = op_i[2];
  assign nbytes = is_stk ? 4'd4 : size_bytes(size_i);
  assign amt    = AW'(nbytes);

  always_comb begin
    add_en          = '0;
    sub_en          = '0;
    add_en[SEL_DAT] = op_valid_i && is_dat && post_inc_i;
    add_en[SEL_PER] = op_valid_i && is_per && post_inc_i;
    add_en[SEL_STK] = op_valid_i && (op == OP_PUSH);
    sub_en[SEL_STK] = op_valid_i && (op == OP_PULL);
  end

  always_comb begin
    if (is_dat)              mem_addr_o = dat_q;
    else if (is_per)         mem_addr_o = per_q;
    else if (op == OP_PULL)  mem_addr_o = stk_q - WORD_STEP;  // pre-decrement
    else                     mem_addr_o = stk_q;
  end

  assign mem_req_o = op_valid_i;
  assign mem_we_o  = op_valid_i && op_writes(op);
  assign mem_per_o = op_valid_i && is_per;

  asu_ptr_regs #(.AW(AW), .NPTR(NPTR)) i_ptr_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (set_en_i),
    .set_sel_i (set_sel_i),
    .set_val_i (set_val_i),
    .add_en_i  (add_en),
    .sub_en_i  (sub_en),
    .amt_i     (amt),
    .ptr_o     (ptr)
  );

  asu_lane_gen #(.DW(DW)) i_lane_gen (
    .req_i     (op_valid_i),
    .addr_lo_i (mem_addr_o[OW-1:0]),
    .nbytes_i  (nbytes),
    .wdata_i   (st_data_i),
    .be_o      (mem_be_o),
    .wdata_o   (mem_wdata_o)
  );

  asu_load_align #(.DW(DW)) i_load_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (op_valid_i && !op_writes(op)),
    .addr_lo_i  (mem_addr_o[OW-1:0]),
    .nbytes_i   (nbytes),
    .rdata_i    (mem_rdata_i),
    .ld_valid_o (ld_valid_o),
    .ld_data_o  (ld_data_o)
  );
endmodule

// File: rtl/asu_chk.sv
module asu_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  localparam int NL = DW / 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_valid_i,
  input logic [2:0]    op_i,
  input logic [1:0]    size_i,
  input logic          post_inc_i,
  input logic          set_en_i,
  input logic [1:0]    set_sel_i,
  input logic          mem_we_o,
  input logic [NL-1:0] mem_be_o,
  input logic          ld_valid_o,
  input logic [AW-1:0] dat_q,
  input logic [AW-1:0] stk_q
);
  localparam logic [AW-1:0] FOUR = AW'(4);
  logic set_stk, set_dat;
  assign set_stk = set_en_i && (set_sel_i == 2'd2);
  assign set_dat = set_en_i && (set_sel_i == 2'd0);

  // R5
  push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i == 3'd4 && !set_stk |=> stk_q == $past(stk_q) + FOUR);
  // R6
  pull_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i == 3'd5 && !set_stk |=> stk_q == $past(stk_q) - FOUR);
  // R7
  stk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i[2:1] == 2'b11 && !set_stk |=> $stable(stk_q));
  // R4
  dat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_i[2:1] == 2'b00 && !post_inc_i && !set_dat |=> $stable(dat_q));
  // R8
  wide_lanes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_i[2] || size_i[1]) |-> $countones(mem_be_o) == 4);
  // R8
  byte_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !op_i[2] && size_i == 2'd0 |-> $countones(mem_be_o) == 1);
  // R9
  read_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !mem_we_o |=> ld_valid_o);
  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |-> mem_be_o == '0 && !mem_we_o);
endmodule

bind addr_step_unit asu_chk #(.AW(AW), .DW(DW)) i_asu_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_i       (op_i),
  .size_i     (size_i),
  .post_inc_i (post_inc_i),
  .set_en_i   (set_en_i),
  .set_sel_i  (set_sel_i),
  .mem_we_o   (mem_we_o),
  .mem_be_o   (mem_be_o),
  .ld_valid_o (ld_valid_o),
  .dat_q      (dat_q),
  .stk_q      (stk_q)
);

// File: tb/test_addr_step_unit.sv
`timescale 1ns/1ps
module test_addr_step_unit;
  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0, post_inc = 0, set_en = 0;
  logic [2:0]  op = 0;
  logic [1:0]  size = 0, set_sel = 0;
  logic [31:0] st_data = 0, set_val = 0, rdata = 0;
  logic        req, we, per, ld_valid;
  logic [31:0] addr, wdata, ld_data;
  logic [3:0]  be;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addr_step_unit i_addr_step_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .size_i(size),
    .post_inc_i(post_inc), .st_data_i(st_data), .set_en_i(set_en), .set_sel_i(set_sel),
    .set_val_i(set_val), .mem_req_o(req), .mem_we_o(we), .mem_per_o(per),
    .mem_addr_o(addr), .mem_be_o(be), .mem_wdata_o(wdata), .mem_rdata_i(rdata),
    .ld_valid_o(ld_valid), .ld_data_o(ld_data));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive one op at negedge, check request outputs, advance one clock
  task automatic issue(input logic [2:0] o, input logic [1:0] s, input logic p,
                       input logic [31:0] d, input logic [31:0] e_addr, input logic e_we,
                       input logic e_per, input logic [3:0] e_be, string tag);
    @(negedge clk);
    op_valid = 1; op = o; size = s; post_inc = p; st_data = d;
    #1;
    chk({tag, " addr"}, addr, e_addr);
    chk({tag, " we"}, {31'd0, we}, {31'd0, e_we});
    chk({tag, " per"}, {31'd0, per}, {31'd0, e_per});
    chk({tag, " be"}, {28'd0, be}, {28'd0, e_be});
    chk({tag, " req"}, {31'd0, req}, 32'd1);
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic set_ptr(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    set_en = 1; set_sel = sel; set_val = v;
    @(negedge clk);
    set_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 ld_valid", {31'd0, ld_valid}, 32'd0);
    chk("R11 idle req", {31'd0, req}, 32'd0);
    issue(3'd0, 2'd0, 0, 0, 32'h0, 0, 0, 4'b0001, "R1 dat");
    issue(3'd2, 2'd2, 0, 0, 32'h0, 0, 1, 4'b1111, "R1 per");
    issue(3'd7, 2'd0, 0, 0, 32'h0, 0, 0, 4'b1111, "R1 stk");
  endtask

  task automatic t_postinc;
    set_ptr(2'd0, 32'h100);
    issue(3'd0, 2'd0, 1, 0, 32'h100, 0, 0, 4'b0001, "R3 byte");
    issue(3'd0, 2'd1, 1, 0, 32'h101, 0, 0, 4'b0011, "R3 short");
    issue(3'd1, 2'd2, 1, 0, 32'h103, 1, 0, 4'b1111, "R3 long");
    issue(3'd1, 2'd3, 1, 0, 32'h107, 1, 0, 4'b1111, "R3 size3");
    issue(3'd0, 2'd0, 0, 0, 32'h10b, 0, 0, 4'b1000, "R3 after");
  endtask

  task automatic t_noinc_spaces;
    issue(3'd0, 2'd2, 0, 0, 32'h10b, 0, 0, 4'b1111, "R4 hold1");
    issue(3'd0, 2'd0, 0, 0, 32'h10b, 0, 0, 4'b1000, "R4 hold2");
    set_ptr(2'd1, 32'h2000);
    issue(3'd3, 2'd0, 1, 0, 32'h2000, 1, 1, 4'b0001, "R2 per st");
    issue(3'd2, 2'd1, 1, 0, 32'h2001, 0, 1, 4'b0011, "R2 per ld");
    issue(3'd0, 2'd0, 0, 0, 32'h10b, 0, 0, 4'b1000, "R2 dat untouched");
    issue(3'd2, 2'd0, 0, 0, 32'h2003, 0, 1, 4'b1000, "R2 per next");
  endtask

  task automatic t_stack;
    set_ptr(2'd2, 32'h400);
    issue(3'd4, 2'd0, 0, 32'h1, 32'h400, 1, 0, 4'b1111, "R5 push1");
    issue(3'd4, 2'd1, 1, 32'h2, 32'h404, 1, 0, 4'b1111, "R5 push2");
    issue(3'd5, 2'd0, 1, 0, 32'h404, 0, 0, 4'b1111, "R6 pull1");
    issue(3'd7, 2'd0, 1, 0, 32'h404, 0, 0, 4'b1111, "R7 ldstk");
    issue(3'd6, 2'd0, 1, 0, 32'h404, 1, 0, 4'b1111, "R7 ststk");
    issue(3'd5, 2'd0, 0, 0, 32'h400, 0, 0, 4'b1111, "R6 pull2");
    issue(3'd7, 2'd0, 0, 0, 32'h400, 0, 0, 4'b1111, "R6 after");
    issue(3'd0, 2'd0, 0, 0, 32'h10b, 0, 0, 4'b1000, "R2 stk leaves dat");
  endtask

  task automatic t_lanes;
    set_ptr(2'd0, 32'h102);
    issue(3'd1, 2'd0, 0, 32'hAABBCCDD, 32'h102, 1, 0, 4'b0100, "R8 byte be");
    @(negedge clk); op_valid = 1; op = 3'd1; size = 2'd0; post_inc = 0; st_data = 32'hAABBCCDD; #1;
    chk("R8 byte wdata", wdata, 32'hDDDDDDDD);
    size = 2'd1; #1;
    chk("R8 short be", {28'd0, be}, 32'h0000000C);
    chk("R8 short wdata", wdata, 32'hCCDDCCDD);
    size = 2'd2; #1;
    chk("R8 long wdata", wdata, 32'hAABBCCDD);
    op_valid = 0; #1;
    chk("R11 idle be", {28'd0, be}, 32'd0);
    chk("R11 idle we", {31'd0, we}, 32'd0);
  endtask

  task automatic ld_test(input logic [1:0] s, input logic [31:0] a, input logic [31:0] rd,
                         input logic [31:0] exp, string tag);
    set_ptr(2'd0, a);
    @(negedge clk);
    op_valid = 1; op = 3'd0; size = s; post_inc = 0;
    @(negedge clk);
    op_valid = 0; rdata = rd; #1;
    chk({tag, " valid"}, {31'd0, ld_valid}, 32'd1);
    chk({tag, " data"}, ld_data, exp);
  endtask

  task automatic t_load;
    ld_test(2'd0, 32'h103, 32'h11223344, 32'h11, "R9 byte3");
    ld_test(2'd0, 32'h101, 32'h11223344, 32'h33, "R9 byte1");
    ld_test(2'd1, 32'h102, 32'h8899AABB, 32'h8899, "R9 short hi");
    ld_test(2'd1, 32'h100, 32'h8899AABB, 32'hAABB, "R9 short lo");
    ld_test(2'd2, 32'h100, 32'hDEADBEEF, 32'hDEADBEEF, "R9 long");
    issue(3'd1, 2'd2, 0, 0, 32'h100, 1, 0, 4'b1111, "R9 store");
    #1 chk("R9 store no valid", {31'd0, ld_valid}, 32'd0);
  endtask

  task automatic t_set_prio;
    @(negedge clk);
    op_valid = 1; op = 3'd0; size = 2'd2; post_inc = 1;
    set_en = 1; set_sel = 2'd0; set_val = 32'h500;
    @(negedge clk);
    op_valid = 0; set_en = 0;
    issue(3'd0, 2'd0, 0, 0, 32'h500, 0, 0, 4'b0001, "R10 set wins");
    @(negedge clk);
    set_en = 1; set_sel = 2'd3; set_val = 32'h777;
    @(negedge clk);
    set_en = 0;
    issue(3'd0, 2'd0, 0, 0, 32'h500, 0, 0, 4'b0001, "R10 sel3 none");
    issue(3'd7, 2'd0, 0, 0, 32'h400, 0, 0, 4'b1111, "R10 sel3 stk");
  endtask

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_postinc();
    t_noinc_spaces();
    t_stack();
    t_lanes();
    t_load();
    t_set_prio();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule